// File: doc/BRIEF.md
# Dual-Supply Dip and Interruption Sequencer

This block produces the on/off control for two high-side supply switches that feed a device under test from two supplies, a main one and a secondary one. It turns a slow timing tick (one pulse per millisecond) into repeated supply dips. Each dip cycle starts with a long separation period in which both switches are closed. A dip period follows, in which the main switch opens and the secondary switch stays closed. The cycle then repeats for as long as the run input is held.

A small test number picks one of five dip lengths. The block takes that number once, when run rises, and holds it until the next start. A test number outside the valid range keeps both switches open. Every period is counted in whole ticks. With no tick the sequencer holds its state, so the real period lengths follow the tick rate.

Top module: `dip_sequencer`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first sampled cycle after it, both drive outputs are low.
- R2: Phase timing advances only on cycles where the tick input is high. While running with no tick, the drive outputs hold their values.
- R3: With test numbers 1, 2, 3, 4 and 5, the dip phase lasts 10, 30, 100, 300 and 1000 ticks respectively.
- R4: The separation phase lasts SEP_TICKS ticks (default 10000, one tick = 1 ms, so 10 s). During it, both drv_v1 and drv_v2 are high.
- R5: During the dip phase, drv_v1 is low and drv_v2 is high.
- R6: When run is sampled low, both outputs are low from the next cycle, and the sequencer is idle.
- R7: A test number of 0, 6 or 7 captured at the start of a run keeps both outputs low for that whole run.
- R8: A start enters the separation phase first. Both outputs rise in the cycle after run is first sampled high. The first dip begins only after a full separation.
- R9: Separation and dip alternate for as long as run stays high, with no limit on the number of dips.
- R10: The test number is captured in the cycle run is first sampled high (3-bit field, value 1..5 valid). Changes to test_sel while running have no effect.
- R11: drv_v1 is never high while drv_v2 is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle timing tick enable |
| run | input | 1 | Run enable; a rising edge starts a sequence |
| test_sel | input | 3 | Test number, captured when run rises |
| drv_v1 | output | 1 | Main supply switch control, high = on |
| drv_v2 | output | 1 | Secondary supply switch control, high = on |

## Verification
A wrong phase state shows up at once: the outputs are a direct decode of the phase register, so it appears as an illegal output pair or a missing dip. A wrong counter value or a wrong table entry shows up only when the phase ends. The bench measures every dip and every separation, in cycles, with the tick held high. A wrong test capture shows up as a dip of the wrong length, or as activity in a run that should stay silent.

// File: rtl/dip_seq_pkg.sv
package dip_seq_pkg;

   localparam int TEST_W    = 3;
   localparam int NUM_TESTS = 5;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SEP  = 2'd1,
      PH_DIP  = 2'd2
   } phase_t;

   function automatic logic test_valid(input logic [TEST_W-1:0] t);
      return (t >= TEST_W'(1)) && (t <= TEST_W'(NUM_TESTS));
   endfunction

   function automatic int max_of2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dip_dur_lut.sv
module dip_dur_lut
   import dip_seq_pkg::*;
#(
   parameter int CNT_W  = 10,
   parameter int DUR_T1 = 10,
   parameter int DUR_T2 = 30,
   parameter int DUR_T3 = 100,
   parameter int DUR_T4 = 300,
   parameter int DUR_T5 = 1000
) (
   input  logic [TEST_W-1:0] sel,
   output logic [CNT_W-1:0]  load_val
);

   localparam int ENTRIES = 1 << TEST_W;
   localparam int DURS [NUM_TESTS] = '{DUR_T1, DUR_T2, DUR_T3, DUR_T4, DUR_T5};

   logic [CNT_W-1:0] table_q [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
      if (i >= 1 && i <= NUM_TESTS) begin : g_used
         if (DURS[i-1] < 1) begin : g_bad
            $error("dip_dur_lut: every dip duration must be at least one tick");
         end
         assign table_q[i] = CNT_W'(DURS[i-1] - 1);
      end else begin : g_unused
         assign table_q[i] = '0;
      end
   end

   assign load_val = table_q[sel];

endmodule

// File: rtl/dip_phase_cnt.sv
module dip_phase_cnt #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             at_zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec && (cnt_q != '0)) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign at_zero = (cnt_q == '0);

endmodule

// File: rtl/dip_seq_fsm.sv
module dip_seq_fsm
   import dip_seq_pkg::*;
#(
   parameter int CNT_W     = 14,
   parameter int SEP_TICKS = 10000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              run,
   input  logic [TEST_W-1:0] test_sel,
   input  logic              cnt_zero,
   input  logic [CNT_W-1:0]  dip_load,
   output phase_t            phase,
   output logic              cnt_load,
   output logic [CNT_W-1:0]  cnt_val,
   output logic              run_prev,
   output logic [TEST_W-1:0] test_cap
);

   localparam logic [CNT_W-1:0] SEP_LOAD = CNT_W'(SEP_TICKS - 1);

   phase_t phase_q;
   logic   start_ev;
   logic   expire_ev;

   assign start_ev  = run && !run_prev;
   assign expire_ev = run && run_prev && tick && cnt_zero && (phase_q != PH_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q  <= PH_IDLE;
         run_prev <= 1'b0;
         test_cap <= '0;
      end else begin
         run_prev <= run;
         if (!run) begin
            phase_q <= PH_IDLE;
         end else if (start_ev) begin
            test_cap <= test_sel;
            phase_q  <= test_valid(test_sel) ? PH_SEP : PH_IDLE;
         end else if (expire_ev) begin
            unique case (phase_q)
               PH_SEP:  phase_q <= PH_DIP;
               PH_DIP:  phase_q <= PH_SEP;
               default: phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      cnt_load = 1'b0;
      cnt_val  = SEP_LOAD;
      if (start_ev && test_valid(test_sel)) begin
         cnt_load = 1'b1;
         cnt_val  = SEP_LOAD;
      end else if (expire_ev) begin
         cnt_load = 1'b1;
         cnt_val  = (phase_q == PH_SEP) ? dip_load : SEP_LOAD;
      end
   end

   assign phase = phase_q;

endmodule

// File: rtl/dip_sequencer.sv
module dip_sequencer
   import dip_seq_pkg::*;
#(
   parameter int SEP_TICKS = 10000,
   parameter int DUR_T1    = 10,
   parameter int DUR_T2    = 30,
   parameter int DUR_T3    = 100,
   parameter int DUR_T4    = 300,
   parameter int DUR_T5    = 1000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_1ms,
   input  logic              run,
   input  logic [TEST_W-1:0] test_sel,
   output logic              drv_v1,
   output logic              drv_v2
);

   localparam int MAX_DIP = max_of2(max_of2(max_of2(DUR_T1, DUR_T2), max_of2(DUR_T3, DUR_T4)), DUR_T5);
   localparam int MAX_DUR = max_of2(MAX_DIP, SEP_TICKS);
   localparam int CNT_W   = max_of2(1, $clog2(MAX_DUR));

   if (SEP_TICKS < 1) begin : g_bad_sep
      $error("dip_sequencer: SEP_TICKS must be at least one tick");
   end

   phase_t            phase;
   logic              cnt_load;
   logic [CNT_W-1:0]  cnt_val;
   logic              cnt_zero;
   logic [CNT_W-1:0]  dip_load;
   logic              run_prev;
   logic [TEST_W-1:0] test_cap;

   dip_dur_lut #(
      .CNT_W (CNT_W),
      .DUR_T1(DUR_T1),
      .DUR_T2(DUR_T2),
      .DUR_T3(DUR_T3),
      .DUR_T4(DUR_T4),
      .DUR_T5(DUR_T5)
   ) u_lut (
      .sel     (test_cap),
      .load_val(dip_load)
   );

   dip_phase_cnt #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .load    (cnt_load),
      .load_val(cnt_val),
      .dec     (tick_1ms),
      .at_zero (cnt_zero)
   );

   dip_seq_fsm #(
      .CNT_W    (CNT_W),
      .SEP_TICKS(SEP_TICKS)
   ) u_fsm (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick_1ms),
      .run     (run),
      .test_sel(test_sel),
      .cnt_zero(cnt_zero),
      .dip_load(dip_load),
      .phase   (phase),
      .cnt_load(cnt_load),
      .cnt_val (cnt_val),
      .run_prev(run_prev),
      .test_cap(test_cap)
   );

   assign drv_v1 = (phase == PH_SEP);
   assign drv_v2 = (phase != PH_IDLE);

endmodule

// File: rtl/dip_sequencer_chk.sv
module dip_sequencer_chk
   import dip_seq_pkg::*;
(
   input logic              clk,
   input logic              rst,
   input logic              tick_1ms,
   input logic              run,
   input logic [TEST_W-1:0] test_sel,
   input logic              drv_v1,
   input logic              drv_v2,
   input logic              run_prev,
   input logic [TEST_W-1:0] test_cap
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) rst |=> (!drv_v1 && !drv_v2));

   // R6
   stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !run |=> (!drv_v1 && !drv_v2));

   // R11
   v1_needs_v2_chk: assert property (@(posedge clk) disable iff (rst)
      drv_v1 |-> drv_v2);

   // R2
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (run && run_prev && !tick_1ms) |=> ($stable(drv_v1) && $stable(drv_v2)));

   // R8
   start_sep_first_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(drv_v2) |-> drv_v1);

   // R7
   bad_test_silent_chk: assert property (@(posedge clk) disable iff (rst)
      (run && !run_prev && !test_valid(test_sel)) |=> !drv_v2);

   // R10
   capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (run && run_prev) |=> $stable(test_cap));

endmodule

bind dip_sequencer dip_sequencer_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .tick_1ms(tick_1ms),
   .run     (run),
   .test_sel(test_sel),
   .drv_v1  (drv_v1),
   .drv_v2  (drv_v2),
   .run_prev(run_prev),
   .test_cap(test_cap)
);

// File: tb/tb_dip_sequencer.sv
module tb_dip_sequencer;

   localparam int SEP = 40;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick_1ms = 1'b0;
   logic       run = 1'b0;
   logic [2:0] test_sel = 3'd0;
   logic       drv_v1;
   logic       drv_v2;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   dip_sequencer #(.SEP_TICKS(SEP)) dut (
      .clk     (clk),
      .rst     (rst),
      .tick_1ms(tick_1ms),
      .run     (run),
      .test_sel(test_sel),
      .drv_v1  (drv_v1),
      .drv_v2  (drv_v2)
   );

   always #5 clk = ~clk;

   function automatic int exp_dur(input int t);
      case (t)
         1: return 10;
         2: return 30;
         3: return 100;
         4: return 300;
         5: return 1000;
         default: return 0;
      endcase
   endfunction

   // reference model: 0 idle, 1 separation, 2 dip
   int m_ph = 0;
   int m_el = 0;
   int m_test = 0;
   bit m_prev = 1'b0;

   // measurement state (valid only when every cycle carries a tick)
   bit meas_en = 1'b0;
   int len_hi = 0;
   int len_dip = 0;
   int dips_seen = 0;
   bit p_v1 = 1'b0;
   bit p_v2 = 1'b0;
   int cur_test = 0;

   task automatic check(input string tag, input int got, input int exp);
      n_tests++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic void model_step(input bit r, input bit rn, input int ts, input bit tk);
      if (r) begin
         m_ph = 0; m_el = 0; m_prev = 1'b0; m_test = 0;
         return;
      end
      if (!rn) begin
         m_ph = 0;
      end else if (!m_prev) begin
         m_test = ts;
         m_el = 0;
         m_ph = (ts >= 1 && ts <= 5) ? 1 : 0;
      end else if (tk && m_ph != 0) begin
         m_el++;
         if (m_ph == 1 && m_el == SEP) begin
            m_ph = 2; m_el = 0;
         end else if (m_ph == 2 && m_el == exp_dur(m_test)) begin
            m_ph = 1; m_el = 0;
         end
      end
      m_prev = rn;
   endfunction

   task automatic observe();
      string tag;
      tag = (m_ph == 0) ? "R6" : ((m_ph == 1) ? "R4" : "R5");
      check({tag, " drv_v1"}, int'(drv_v1), int'(m_ph == 1));
      check({tag, " drv_v2"}, int'(drv_v2), int'(m_ph != 0));
      if (meas_en) begin
         if (drv_v1 && drv_v2) len_hi++;
         if (!drv_v1 && drv_v2) len_dip++;
         if (p_v1 && p_v2 && !drv_v1 && drv_v2) begin
            // R4 and R8: full separation measured before each dip
            check("R4 separation length", len_hi, SEP);
            len_dip = 1;
            dips_seen++;
         end
         if (!p_v1 && p_v2 && drv_v1 && drv_v2) begin
            check("R3 dip length", len_dip, exp_dur(cur_test));
            len_hi = 1;
         end
         if (!drv_v2) begin len_hi = 0; len_dip = 0; end
      end
      p_v1 = drv_v1;
      p_v2 = drv_v2;
   endtask

   task automatic cycle(input bit r, input bit rn, input int ts, input bit tk);
      @(negedge clk);
      observe();
      if (rn && !run) cur_test = ts;
      rst = r; run = rn; test_sel = 3'(ts); tick_1ms = tk;
      model_step(r, rn, ts, tk);
   endtask

   initial begin
      // R1: reset state
      cycle(1, 0, 0, 1);
      cycle(1, 1, 3, 1);
      cycle(0, 0, 0, 1);
      check("R1 drv_v1 after reset", int'(drv_v1), 0);
      check("R1 drv_v2 after reset", int'(drv_v2), 0);

      // R3 R4 R8 R10: every test, ticks every cycle, test_sel scrambled while running
      meas_en = 1'b1;
      for (int t = 1; t <= 5; t++) begin
         int n;
         n = 2 * (SEP + exp_dur(t)) + 5;
         cycle(0, 1, t, 1);
         for (int k = 0; k < n; k++) cycle(0, 1, int'($urandom_range(0, 7)), 1);
         cycle(0, 0, 0, 1);
         cycle(0, 0, 0, 1);
         check("R6 v2 low after stop", int'(drv_v2), 0);
      end

      // R9: many dips in one run
      dips_seen = 0;
      cycle(0, 1, 1, 1);
      for (int k = 0; k < 5 * (SEP + 10); k++) cycle(0, 1, 1, 1);
      check("R9 dips repeat (>=4)", int'(dips_seen >= 4), 1);
      cycle(0, 0, 0, 1);
      meas_en = 1'b0;

      // R7: invalid tests stay silent
      for (int t = 0; t < 3; t++) begin
         int ts;
         ts = (t == 0) ? 0 : t + 5;
         cycle(0, 1, ts, 1);
         for (int k = 0; k < 60; k++) cycle(0, 1, 2, 1);
         check("R7 silent run v2", int'(drv_v2), 0);
         cycle(0, 0, 0, 1);
      end

      // R2: no tick, outputs hold
      cycle(0, 1, 1, 1);
      for (int k = 0; k < SEP + 3; k++) cycle(0, 1, 1, 0);
      check("R2 still in separation v1", int'(drv_v1), 1);
      cycle(0, 0, 0, 0);

      // random mix with gappy ticks, rare run toggles, one mid-run reset
      void'($urandom(32'd1234));
      for (int k = 0; k < 6000; k++) begin
         bit rn;
         rn = (k % 700 < 650);
         cycle((k == 3333), rn, int'($urandom_range(0, 7)), ($urandom_range(0, 1) == 1));
      end
      cycle(0, 0, 0, 0);
      cycle(0, 0, 0, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule